// File: doc/BRIEF.md
# Toggle-Weighted Power Estimator

This block is a hardware power model that sits beside one monitored datapath component. The component's input bits arrive on a single concatenated bus. The block only samples that bus when a power strobe arrives, not on every clock edge. For each evaluation it compares every monitored bit with its value at the previous accepted strobe. Every bit that changed contributes its own weight. A constant base weight is always added. The weights come from a small coefficient memory that an external loader fills.

To save area, the block does not add all weights in one wide adder tree. It walks the coefficient memory one entry per clock cycle and builds the sum in a single accumulator. The result appears with a one-cycle valid pulse.

In batch mode the block collects a group of K strobed samples and evaluates only after the last one. That evaluation adds up the toggles across the whole group, including the step from the sample taken before the group. This trades a little sample storage for fewer evaluations.

Top module: `tog_power_model`

## Requirements
- R1: The result is (n × coefficient at address 0) plus, for every monitored bit i, the number of times mon_in[i] changed between consecutive samples of the evaluated group, multiplied by the coefficient at address i+1. The sum is taken modulo 2^32. n is 1 in single mode and BATCH_K in batch mode.
- R2: At the first accepted strobe after reset, the previous sample is taken to equal the sample just captured. In single mode that evaluation therefore yields exactly the address-0 coefficient.
- R3: Each group is compared against the sample captured at the most recent accepted strobe before the group.
- R4: power_vld is a one-cycle pulse. It rises NBITS+2 rising clock edges after the edge that accepted the completing strobe (34 with defaults). busy is high in between. power holds its value whenever power_vld is low.
- R5: A strobe that arrives while busy is high gives a one-cycle overrun pulse in the next cycle. The sample it carries is discarded: it affects neither the running result nor any later result.
- R6: A group started with batch_en high takes BATCH_K accepted strobes. No result appears until the last of them. While the group is filling, busy stays low.
- R7: batch_en is sampled only at the strobe that opens a group. Changing it during a group has no effect on that group.
- R8: With coef_we high, coef_wdata is written to address coef_addr. Writes to addresses above NBITS have no effect. The coefficient contents are kept through reset.
- R9: In reset, power is 0 and power_vld, busy and overrun are 0. Without a strobe, no evaluation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe | input | 1 | Power strobe: sample mon_in, and evaluate when the group is complete |
| mon_in | input | 32 | Monitored component inputs, concatenated; bit i uses coefficient i+1 |
| batch_en | input | 1 | Select batch grouping, sampled at the strobe that opens a group |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 6 | Coefficient address: 0 is the base weight, 1..32 the bit weights |
| coef_wdata | input | 32 | Coefficient write data |
| power | output | 32 | Latest evaluated power word |
| power_vld | output | 1 | One-cycle pulse when power is updated |
| busy | output | 1 | Evaluation walk in progress |
| overrun | output | 1 | One-cycle pulse: a strobe was dropped because the block was busy |

## Verification
The bench goes after the first strobe after reset and after a reset in the middle of the run. A block that compares against a stale or zero history would report spurious toggles there instead of the base weight alone. Strobes that land during a walk are checked twice: the result must belong to the first sample, and the following evaluation must compare against that first sample. A block that let the dropped sample through would corrupt one of these two results. Batch groups are checked for silence until the K-th strobe, and for ignoring a batch_en flip after the group opens. Coefficients near 2^32 check that the sum wraps, and an out-of-range coefficient write must leave every later result unchanged.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

endpackage

// File: rtl/tpm_rst_sync.sv
module tpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/tpm_coef_ram.sv
module tpm_coef_ram #(
  parameter int DEPTH  = 33,
  parameter int COEF_W = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [COEF_W-1:0] rd_data
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic [COEF_W-1:0] mem_q [0:DEPTH-1];
  logic              wr_ok;

  // Out-of-range writes are dropped so they cannot alias onto real entries.
  assign wr_ok = wr_en && (wr_addr <= TOP_ADDR);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_q[wr_addr] <= wr_data;
    end
    if (rd_en) begin
      rd_data <= mem_q[rd_addr];
    end
  end

endmodule

// File: rtl/tpm_sample_hist.sv
module tpm_sample_hist #(
  parameter int NBITS   = 32,
  parameter int BATCH_K = 4,
  parameter int CNT_W   = 3,
  parameter int SEL_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [NBITS-1:0] din,
  input  logic             batch_req,
  input  logic [SEL_W-1:0] sel,
  output logic             start,
  output logic [CNT_W-1:0] n_eval,
  output logic [CNT_W-1:0] tog_cnt
);

  localparam logic [CNT_W-1:0] K_CNT   = CNT_W'(BATCH_K);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  // control and history state
  logic             primed_q, primed_d;
  logic             mode_q,   mode_d;
  logic [CNT_W-1:0] fill_q,   fill_d;
  logic [NBITS-1:0] hist_q,   hist_d;
  logic [NBITS-1:0] base_q,   base_d;

  // group sample store (datapath, no reset)
  logic [NBITS-1:0] smp_q [0:BATCH_K-1];
  logic [NBITS-1:0] smp_d [0:BATCH_K-1];

  logic [CNT_W-1:0] grp_len;
  logic             grp_last;
  logic [BATCH_K-1:0] flip_bits;

  always_comb begin
    if (fill_q == '0) begin
      grp_len = batch_req ? K_CNT : ONE_CNT;
    end else begin
      grp_len = mode_q ? K_CNT : ONE_CNT;
    end
    grp_last = take && (fill_q == grp_len - ONE_CNT);
  end

  always_comb begin
    primed_d = primed_q;
    mode_d   = mode_q;
    fill_d   = fill_q;
    hist_d   = hist_q;
    base_d   = base_q;
    for (int j = 0; j < BATCH_K; j++) begin
      smp_d[j] = smp_q[j];
    end
    if (take) begin
      hist_d   = din;
      primed_d = 1'b1;
      for (int j = 0; j < BATCH_K; j++) begin
        if (fill_q == CNT_W'(j)) begin
          smp_d[j] = din;
        end
      end
      if (fill_q == '0) begin
        // opening strobe: latch the reference sample and the group mode
        base_d = primed_q ? hist_q : din;
        mode_d = batch_req;
      end
      fill_d = grp_last ? '0 : fill_q + ONE_CNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      mode_q   <= 1'b0;
      fill_q   <= '0;
      hist_q   <= '0;
      base_q   <= '0;
    end else begin
      primed_q <= primed_d;
      mode_q   <= mode_d;
      fill_q   <= fill_d;
      hist_q   <= hist_d;
      base_q   <= base_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      for (int j = 0; j < BATCH_K; j++) begin
        smp_q[j] <= smp_d[j];
      end
    end
  end

  // per-sample toggle of the selected bit column
  genvar g;
  generate
    for (g = 0; g < BATCH_K; g++) begin : g_col
      if (g == 0) begin : g_first
        assign flip_bits[g] = smp_q[g][sel] ^ base_q[sel];
      end else begin : g_rest
        assign flip_bits[g] = smp_q[g][sel] ^ smp_q[g-1][sel];
      end
    end
  endgenerate

  always_comb begin
    tog_cnt = '0;
    for (int j = 0; j < BATCH_K; j++) begin
      if (CNT_W'(j) < n_eval) begin
        tog_cnt = tog_cnt + CNT_W'(flip_bits[j]);
      end
    end
  end

  assign n_eval = mode_q ? K_CNT : ONE_CNT;
  assign start  = grp_last;

endmodule

// File: rtl/tpm_walker.sv
module tpm_walker
  import tpm_pkg::*;
#(
  parameter int NBITS  = 32,
  parameter int COEF_W = 32,
  parameter int CNT_W  = 3,
  parameter int SEL_W  = 5,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COEF_W-1:0] rdata,
  input  logic [CNT_W-1:0]  n_eval,
  input  logic [CNT_W-1:0]  tog_cnt,
  output logic              re,
  output logic [AW-1:0]     raddr,
  output logic [SEL_W-1:0]  sel,
  output logic              busy,
  output logic [COEF_W-1:0] power,
  output logic              power_vld
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(NBITS);

  walk_state_e       state_q, state_d;
  logic              issue_q, issue_d;
  logic [AW-1:0]     iaddr_q, iaddr_d;
  logic              dvld_q,  dvld_d;
  logic [AW-1:0]     didx_q,  didx_d;
  logic [COEF_W-1:0] acc_q,   acc_d;
  logic [COEF_W-1:0] pwr_q,   pwr_d;
  logic              vld_q,   vld_d;

  logic [CNT_W-1:0]  weight;
  logic [COEF_W-1:0] term;

  // address 0 carries the base weight, address i+1 bit i
  assign sel    = SEL_W'(didx_q - AW'(1));
  assign weight = (didx_q == '0) ? n_eval : tog_cnt;
  assign term   = rdata * COEF_W'(weight);

  always_comb begin
    state_d = state_q;
    issue_d = issue_q;
    iaddr_d = iaddr_q;
    dvld_d  = 1'b0;
    didx_d  = didx_q;
    acc_d   = acc_q;
    pwr_d   = pwr_q;
    vld_d   = 1'b0;
    case (state_q)
      WALK_IDLE: begin
        if (start) begin
          state_d = WALK_RUN;
          issue_d = 1'b1;
          iaddr_d = '0;
          acc_d   = '0;
        end
      end
      WALK_RUN: begin
        if (issue_q) begin
          iaddr_d = iaddr_q + AW'(1);
          if (iaddr_q == LAST_ADDR) begin
            issue_d = 1'b0;
          end
        end
        dvld_d = issue_q;
        didx_d = iaddr_q;
        if (dvld_q) begin
          acc_d = acc_q + term;
          if (didx_q == LAST_ADDR) begin
            pwr_d   = acc_q + term;
            vld_d   = 1'b1;
            state_d = WALK_IDLE;
          end
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      issue_q <= 1'b0;
      iaddr_q <= '0;
      dvld_q  <= 1'b0;
      didx_q  <= '0;
      acc_q   <= '0;
      pwr_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      issue_q <= issue_d;
      iaddr_q <= iaddr_d;
      dvld_q  <= dvld_d;
      didx_q  <= didx_d;
      acc_q   <= acc_d;
      pwr_q   <= pwr_d;
      vld_q   <= vld_d;
    end
  end

  assign re        = issue_q;
  assign raddr     = iaddr_q;
  assign busy      = (state_q == WALK_RUN);
  assign power     = pwr_q;
  assign power_vld = vld_q;

endmodule

// File: rtl/tog_power_model.sv
module tog_power_model #(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 16,
  parameter int COEF_W    = 32,
  parameter int BATCH_K   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          strobe,
  input  logic [NUM_PORTS*PORT_W-1:0]   mon_in,
  input  logic                          batch_en,
  input  logic                          coef_we,
  input  logic [$clog2(NUM_PORTS*PORT_W+1)-1:0] coef_addr,
  input  logic [COEF_W-1:0]             coef_wdata,
  output logic [COEF_W-1:0]             power,
  output logic                          power_vld,
  output logic                          busy,
  output logic                          overrun
);

  localparam int NBITS = NUM_PORTS * PORT_W;
  localparam int DEPTH = NBITS + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(BATCH_K + 1);
  localparam int SEL_W = $clog2(NBITS);

  logic              rst_n_int;
  logic              take;
  logic              grp_start;
  logic [CNT_W-1:0]  n_eval;
  logic [CNT_W-1:0]  tog_cnt;
  logic [SEL_W-1:0]  sel;
  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic [COEF_W-1:0] rd_data;
  logic              walk_busy;
  logic              ovr_q, ovr_d;

  tpm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // strobes are only accepted between evaluations
  assign take = strobe && !walk_busy;

  always_comb begin
    ovr_d = strobe && walk_busy;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  tpm_sample_hist #(
    .NBITS   (NBITS),
    .BATCH_K (BATCH_K),
    .CNT_W   (CNT_W),
    .SEL_W   (SEL_W)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .take      (take),
    .din       (mon_in),
    .batch_req (batch_en),
    .sel       (sel),
    .start     (grp_start),
    .n_eval    (n_eval),
    .tog_cnt   (tog_cnt)
  );

  tpm_coef_ram #(
    .DEPTH  (DEPTH),
    .COEF_W (COEF_W),
    .AW     (AW)
  ) u_ram (
    .clk     (clk),
    .wr_en   (coef_we),
    .wr_addr (coef_addr),
    .wr_data (coef_wdata),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  tpm_walker #(
    .NBITS  (NBITS),
    .COEF_W (COEF_W),
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W),
    .AW     (AW)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (grp_start),
    .rdata     (rd_data),
    .n_eval    (n_eval),
    .tog_cnt   (tog_cnt),
    .re        (rd_en),
    .raddr     (rd_addr),
    .sel       (sel),
    .busy      (walk_busy),
    .power     (power),
    .power_vld (power_vld)
  );

  assign busy    = walk_busy;
  assign overrun = ovr_q;

endmodule

// File: rtl/tpm_chk.sv
module tpm_chk #(
  parameter int COEF_W   = 32,
  parameter int WALK_LEN = 34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic              busy,
  input logic              power_vld,
  input logic              overrun,
  input logic [COEF_W-1:0] power
);

  logic [15:0] busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= '0;
    end else if (busy) begin
      busy_cnt_q <= busy_cnt_q + 16'd1;
    end else begin
      busy_cnt_q <= '0;
    end
  end

  // R4: the valid flag lasts one cycle
  p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    power_vld |=> !power_vld);

  // R4: the power word only moves together with the valid flag
  p_power_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !power_vld |-> $stable(power));

  // R4: every walk lasts the fixed number of cycles
  p_walk_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt_q == 16'(WALK_LEN)));

  // R4: a walk always ends with a result
  p_done_clears_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> power_vld);

  // R5: overrun only follows a strobe that met a busy block
  p_overrun_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(strobe && busy));

  // R9: no evaluation starts without a strobe
  p_start_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(strobe));

endmodule

bind tog_power_model tpm_chk #(
  .COEF_W   (COEF_W),
  .WALK_LEN (NBITS + 2)
) u_tpm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strobe    (strobe),
  .busy      (busy),
  .power_vld (power_vld),
  .overrun   (overrun),
  .power     (power)
);

// File: tb/tog_power_model_test.sv
`timescale 1ns/1ps
module tog_power_model_test;

  localparam int NBITS = 32;
  localparam int K     = 4;
  localparam int WALK  = NBITS + 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic [31:0] mon_in;
  logic        batch_en;
  logic        coef_we;
  logic [5:0]  coef_addr;
  logic [31:0] coef_wdata;
  logic [31:0] power;
  logic        power_vld;
  logic        busy;
  logic        overrun;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] mcoef [0:NBITS];
  logic [31:0] grp   [0:K-1];
  logic [31:0] mprev;
  bit          primed;

  always #2.5 clk = ~clk;

  tog_power_model uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .mon_in     (mon_in),
    .batch_en   (batch_en),
    .coef_we    (coef_we),
    .coef_addr  (coef_addr),
    .coef_wdata (coef_wdata),
    .power      (power),
    .power_vld  (power_vld),
    .busy       (busy),
    .overrun    (overrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_power(input logic [31:0] pv, input int n);
    logic [31:0] acc;
    logic [31:0] t;
    acc = 32'(n) * mcoef[0];
    for (int j = 0; j < n; j++) begin
      t = grp[j] ^ ((j == 0) ? pv : grp[j-1]);
      for (int b = 0; b < NBITS; b++) begin
        if (t[b]) acc = acc + mcoef[b+1];
      end
    end
    return acc;
  endfunction

  task automatic write_coef(input logic [5:0] a, input logic [31:0] v);
    coef_we = 1'b1; coef_addr = a; coef_wdata = v;
    @(negedge clk);
    coef_we = 1'b0;
    if (a <= 6'(NBITS)) mcoef[a] = v;
  endtask

  task automatic pulse_strobe(input logic [31:0] d, input bit be);
    mon_in = d; batch_en = be; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic wait_result(input logic [31:0] exp, input string req, input bit chk_lat);
    int lat;
    logic [31:0] held;
    lat = 0;
    while (!power_vld && lat < 200) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    if (chk_lat) check(lat == WALK, "R4 latency", 32'(lat), 32'(WALK));
    check(power_vld && power == exp, req, power, exp);
    held = power;
    @(negedge clk);
    check(!power_vld && power == held, "R4 pulse/hold", {31'b0, power_vld}, 32'b0);
  endtask

  task automatic run_single(input logic [31:0] d, input string req);
    logic [31:0] pv;
    pv = primed ? mprev : d;
    grp[0] = d;
    pulse_strobe(d, 1'b0);
    mprev = d; primed = 1'b1;
    wait_result(exp_power(pv, 1), req, 1'b1);
  endtask

  task automatic run_batch(input bit flip);
    logic [31:0] pv;
    for (int j = 0; j < K; j++) begin
      grp[j] = $urandom;
      if (j == 0) pv = primed ? mprev : grp[0];
      pulse_strobe(grp[j], (j == 0) ? 1'b1 : !flip);
      if (j < K - 1) begin
        repeat (3) @(negedge clk);
        check(!power_vld && !busy, flip ? "R7 group mode held" : "R6 silent while filling",
              {30'b0, power_vld, busy}, 32'b0);
      end
    end
    mprev = grp[K-1]; primed = 1'b1;
    wait_result(exp_power(pv, K), flip ? "R7 batch value" : "R6 batch value", 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(power == 32'b0 && !power_vld && !busy && !overrun, "R9 reset state",
          {power[28:0], power_vld, busy, overrun}, 32'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    primed = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d1;
    logic [31:0] d2;
    logic [31:0] e1;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; strobe = 1'b0; mon_in = '0; batch_en = 1'b0;
    coef_we = 1'b0; coef_addr = '0; coef_wdata = '0; primed = 1'b0; mprev = '0;
    @(negedge clk);
    do_reset();

    for (int a = 0; a <= NBITS; a++) write_coef(6'(a), $urandom & 32'h00FF_FFFF);

    // R2: first strobe after reset sees no toggles
    run_single($urandom, "R2 first strobe gives base");

    // R9: idle clocks never start an evaluation
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!busy && !power_vld, "R9 no strobe no result", {30'b0, busy, power_vld}, 32'b0);
    end

    // R1/R3: directed patterns, then random
    run_single(32'h0000_0000, "R1/R3 single");
    run_single(32'hFFFF_FFFF, "R1 all bits toggle");
    run_single(32'hFFFF_FFFF, "R1/R3 no toggle");
    run_single(32'h8000_0001, "R1 edge bits");
    for (int i = 0; i < 30; i++) run_single($urandom, "R1/R3 random single");

    // R5: a strobe during a walk is dropped
    d1 = $urandom; d2 = ~d1;
    grp[0] = d1;
    e1 = exp_power(mprev, 1);
    pulse_strobe(d1, 1'b0);
    mprev = d1;
    repeat (5) @(negedge clk);
    pulse_strobe(d2, 1'b1);
    check(overrun == 1'b1, "R5 overrun flagged", {31'b0, overrun}, 32'd1);
    @(negedge clk);
    check(overrun == 1'b0, "R5 overrun one cycle", {31'b0, overrun}, 32'd0);
    wait_result(e1, "R5 running result kept", 1'b0);
    run_single($urandom, "R5 dropped sample not in history");

    // R6/R7: batch groups
    for (int i = 0; i < 3; i++) run_batch(1'b0);
    for (int i = 0; i < 3; i++) run_batch(1'b1);
    run_single($urandom, "R3 single after batch");

    // R8: out-of-range write is ignored, in-range write takes effect
    write_coef(6'd40, 32'hDEAD_BEEF);
    write_coef(6'd63, 32'h1234_5678);
    run_single($urandom, "R8 out-of-range write ignored");
    write_coef(6'd0, 32'h0000_0100);
    write_coef(6'd5, 32'h0001_0000);
    run_single(mprev ^ 32'h0000_0010, "R8 rewritten coefficient");

    // R1: wrap modulo 2^32
    for (int a = 0; a <= NBITS; a++) write_coef(6'(a), 32'hF000_0000 | 32'(a));
    run_single(~mprev, "R1 sum wraps");
    run_batch(1'b0);

    // R2/R8: reset mid-run, history cleared, coefficients kept
    do_reset();
    run_single($urandom, "R2/R8 first strobe after second reset");
    run_single($urandom, "R8 coefficients kept through reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule